// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small 32-bit integer processor core that finishes each instruction in one clock cycle. On every rising edge it commits the result of the instruction addressed by its program counter. It writes a register or a data word, and it moves the program counter to the next address, a branch target or a jump target. All instruction classes share one datapath. Source-select multiplexers decide where the second ALU operand, the destination register number, the write-back value and the next program counter come from. A branch is taken only when the decoder marks a branch and the ALU reports a zero difference.

Instruction storage and data storage are word-addressed arrays inside the block. While reset is held, a loader port fills both arrays: one flag picks the target array and a word index picks the location. Once reset is released the core runs from address 0.

The outcome of every cycle is visible at the ports:
- the current program counter;
- the register write that the cycle commits, as enable, register number and value;
- the store that the cycle commits, as enable, byte address and data.

A separate read port returns any data word. Together these let a bench compare the core against its own instruction-level model.

Top module: `sc_core`

## Requirements
- R1: While reset is low, the program counter reads 0 and no register write or store is reported. Asserting reset during a run returns the program counter to 0 at once and clears every register.
- R2: An instruction that neither jumps nor takes a branch moves the program counter to PC + 4.
- R3: Opcode 0x00 with function code 0x20, 0x22, 0x24, 0x25 or 0x2A writes rd with rs+rt, rs−rt, rs AND rt, rs OR rt, or the signed comparison rs<rt as 1 or 0.
- R4: Opcode 0x08 writes rt with rs plus the sign-extended 16-bit immediate in bits [15:0].
- R5: Opcode 0x23 writes rt with the data word at byte address rs + sign-extended immediate. The word index is address bits [7:2] for the default 64-word array.
- R6: Opcode 0x2B stores rt to the data word at byte address rs + sign-extended immediate, and it writes no register.
- R7: Opcode 0x04 moves the program counter to PC + 4 + (sign-extended immediate × 4) when rs equals rt, and to PC + 4 otherwise.
- R8: Opcode 0x02 moves the program counter to {PC[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as 0, and a write aimed at it is dropped and not reported.
- R10: An opcode outside {0x00, 0x02, 0x04, 0x08, 0x23, 0x2B}, or opcode 0x00 with any other function code, writes nothing and advances to PC + 4.
- R11: A register written by one instruction is read with its new value by the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; loading is only accepted while it is low |
| load_en | input | 1 | Loader write strobe (honoured only while in reset) |
| load_imem | input | 1 | Loader target: 1 selects instruction storage, 0 selects data storage |
| load_addr | input | LAW (6) | Loader word index |
| load_data | input | 32 | Loader word value |
| peek_addr | input | DAW (6) | Word index for the data read-out port |
| peek_data | output | 32 | Data word at peek_addr |
| pc_o | output | 32 | Program counter of the instruction executing this cycle |
| wb_en_o | output | 1 | A register write is committed at the coming edge |
| wb_reg_o | output | 5 | Destination register number of that write |
| wb_data_o | output | 32 | Value of that write |
| st_en_o | output | 1 | A store is committed at the coming edge |
| st_addr_o | output | 32 | Byte address of that store |
| st_data_o | output | 32 | Data of that store |

## Verification
The case that is hardest to reach from the ports is a backward taken branch that closes a loop. The branch decision depends on a register whose value the loop itself changes every pass, so the compare result flips only on the final iteration. The bench runs a count-down loop in which the backward branch is taken twice and a forward exit branch fires on the third pass. A lockstep instruction model checks the program counter and every committed write on each cycle, so a wrong offset sign, a miscounted pass or a stale read shows up at the exact cycle it happens. A second hard case is a write aimed at register 0 followed directly by a read of it. The bench places the two instructions back to back.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  typedef logic [XLEN-1:0] word_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    legal;
    logic    reg_write;
    logic    dst_rd;
    logic    alu_imm;
    logic    mem_write;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
    alu_op_e aop;
  } ctrl_t;

  function automatic word_t sext16(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic word_t branch_target(input word_t pc_plus4, input word_t imm32);
    return pc_plus4 + {imm32[XLEN-3:0], 2'b00};
  endfunction

  function automatic word_t jump_target(input word_t pc, input logic [25:0] idx);
    return {pc[31:28], idx, 2'b00};
  endfunction

  function automatic word_t alu_eval(input alu_fn_e fn, input word_t a, input word_t b);
    word_t r;
    case (fn)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output alu_fn_e    fn
);
  logic funct_known;

  always_comb begin
    case (funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: funct_known = 1'b1;
      default:                               funct_known = 1'b0;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_RTYPE: begin
        ctl.legal     = funct_known;
        ctl.reg_write = funct_known;
        ctl.dst_rd    = 1'b1;
        ctl.aop       = AOP_FUNCT;
      end
      OPC_ADDI: begin
        ctl.legal     = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
        ctl.aop       = AOP_ADD;
      end
      OPC_LOAD: begin
        ctl.legal      = 1'b1;
        ctl.reg_write  = 1'b1;
        ctl.alu_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.aop        = AOP_ADD;
      end
      OPC_STORE: begin
        ctl.legal     = 1'b1;
        ctl.alu_imm   = 1'b1;
        ctl.mem_write = 1'b1;
        ctl.aop       = AOP_ADD;
      end
      OPC_BEQ: begin
        ctl.legal  = 1'b1;
        ctl.branch = 1'b1;
        ctl.aop    = AOP_SUB;
      end
      OPC_JUMP: begin
        ctl.legal = 1'b1;
        ctl.jump  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    case (ctl.aop)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
    endcase
  end

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_write |-> (!ctl.reg_write && !ctl.jump && !ctl.branch));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.legal |-> (!ctl.reg_write && !ctl.mem_write && !ctl.branch && !ctl.jump));
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  alu_fn_e fn,
  input  word_t   a,
  input  word_t   b,
  output word_t   y,
  output logic    zero
);
  assign y    = alu_eval(fn, a, b);
  assign zero = (y == '0);

  // R3
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == ALU_SLT) |-> (y[XLEN-1:1] == '0));

  // R7
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == ALU_SUB) |-> (zero == (a == b)));
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
  import sc_pkg::*;
#(
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output word_t         rd1,
  output word_t         rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  word_t         wd
);
  word_t q [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_reg
    if (gi == 0) begin : g_zero
      assign q[gi] = '0;
    end else begin : g_ff
      logic  hit;
      word_t r;
      assign hit = we && (wa == AW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r <= '0;
        else if (hit) r <= wd;
      end
      assign q[gi] = r;
    end
  end

  assign rd1 = q[ra1];
  assign rd2 = q[ra2];

  // R9
  r0_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));

  // R11
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0)) |=> (q[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_mem.sv
`timescale 1ns/1ps
module sc_mem
  import sc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int RPORTS = 1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              wa,
  input  word_t                      wd,
  input  logic [RPORTS-1:0][AW-1:0]  ra,
  output logic [RPORTS-1:0][XLEN-1:0] rd
);
  word_t m [DEPTH];

  always_ff @(posedge clk) begin
    if (we) m[wa] <= wd;
  end

  for (genvar gp = 0; gp < RPORTS; gp++) begin : g_rport
    assign rd[gp] = m[ra[gp]];
  end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           load_imem,
  input  logic [LAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  input  logic [DAW-1:0] peek_addr,
  output logic [31:0]    peek_data,
  output logic [31:0]    pc_o,
  output logic           wb_en_o,
  output logic [4:0]     wb_reg_o,
  output logic [31:0]    wb_data_o,
  output logic           st_en_o,
  output logic [31:0]    st_addr_o,
  output logic [31:0]    st_data_o
);
  // program counter and fetch
  word_t pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
  word_t instr;
  logic  br_take;

  logic [5:0]     f_op, f_fn;
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]    f_imm;
  logic [25:0]    f_idx;

  ctrl_t   ctl;
  alu_fn_e alu_fn;

  word_t rs_val, rt_val, imm32, alu_b, alu_y, dm_rdata, wb_val;
  logic  alu_zero;
  logic [RAW-1:0] dst;
  logic  rf_we, core_st;

  logic imem_we, dmem_we;
  logic [DAW-1:0] dmem_wa;
  word_t dmem_wd;
  logic [0:0][IAW-1:0]  imem_ra;
  logic [0:0][XLEN-1:0] imem_rd;
  logic [1:0][DAW-1:0]  dmem_ra;
  logic [1:0][XLEN-1:0] dmem_rd;

  // loader: only while reset holds the core
  assign imem_we = !rst_n && load_en && load_imem;
  assign imem_ra[0] = pc_q[IAW+1:2];

  sc_mem #(.DEPTH(IMEM_DEPTH), .RPORTS(1)) u_imem (
    .clk(clk), .we(imem_we), .wa(load_addr[IAW-1:0]), .wd(load_data),
    .ra(imem_ra), .rd(imem_rd)
  );
  assign instr = imem_rd[0];

  // field split
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_idx = instr[25:0];

  sc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(f_op), .funct(f_fn), .ctl(ctl), .fn(alu_fn)
  );

  // register file
  assign dst   = ctl.dst_rd ? f_rd : f_rt;
  assign rf_we = rst_n && ctl.reg_write;

  sc_regfile #(.N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(f_rs), .ra2(f_rt), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(dst), .wd(wb_val)
  );

  // execute
  assign imm32 = sext16(f_imm);
  assign alu_b = ctl.alu_imm ? imm32 : rt_val;

  sc_alu u_alu (
    .clk(clk), .rst_n(rst_n), .fn(alu_fn), .a(rs_val), .b(alu_b),
    .y(alu_y), .zero(alu_zero)
  );

  // data storage
  assign core_st = rst_n && ctl.mem_write;
  assign dmem_we = core_st || (!rst_n && load_en && !load_imem);
  assign dmem_wa = rst_n ? alu_y[DAW+1:2] : load_addr[DAW-1:0];
  assign dmem_wd = rst_n ? rt_val : load_data;
  assign dmem_ra[0] = alu_y[DAW+1:2];
  assign dmem_ra[1] = peek_addr;

  sc_mem #(.DEPTH(DMEM_DEPTH), .RPORTS(2)) u_dmem (
    .clk(clk), .we(dmem_we), .wa(dmem_wa), .wd(dmem_wd),
    .ra(dmem_ra), .rd(dmem_rd)
  );
  assign dm_rdata  = dmem_rd[0];
  assign peek_data = dmem_rd[1];

  assign wb_val = ctl.mem_to_reg ? dm_rdata : alu_y;

  // next program counter
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = branch_target(pc_plus4, imm32);
  assign jmp_tgt  = jump_target(pc_q, f_idx);
  assign br_take  = ctl.branch && alu_zero;

  always_comb begin
    if (ctl.jump)     pc_next = jmp_tgt;
    else if (br_take) pc_next = br_tgt;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  // observation ports
  assign pc_o      = pc_q;
  assign wb_en_o   = rf_we && (dst != '0);
  assign wb_reg_o  = dst;
  assign wb_data_o = wb_val;
  assign st_en_o   = core_st;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;

  // R1
  pc_reset_chk: assert property (@(posedge clk) !rst_n |=> (pc_q == '0));

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7
  br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (pc_q == $past(br_tgt)));

  // R8
  jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jump |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en, load_imem;
  logic [5:0]  load_addr, peek_addr;
  logic [31:0] load_data, peek_data;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]  wb_reg_o;
  logic        wb_en_o, st_en_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog  [64];
  logic [31:0] dinit [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_imem(load_imem),
    .load_addr(load_addr), .load_data(load_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o),
    .st_data_o(st_data_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] r_i(input logic [5:0] fn, input logic [4:0] rd,
                                      input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_i(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] j_i(input logic [25:0] idx);
    return {6'h02, idx};
  endfunction
  function automatic logic [31:0] halt_i();
    return i_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      prog[i]  = 32'h0;
      dinit[i] = 32'hC0DE0000 ^ (i * 32'h01010101);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    m_pc = 32'h0;
  endtask

  // load both arrays under reset, then release
  task automatic start(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) begin
      load_en   = 1'b1;
      load_imem = (i < 64);
      load_addr = 6'(i % 64);
      load_data = (i < 64) ? prog[i % 64] : dinit[i % 64];
      @(negedge clk);
    end
    load_en = 1'b0;
    for (int i = 0; i < 64; i++) m_mem[i] = dinit[i];
    model_reset();
    #1;
    chk(req, "reset pc", pc_o, 32'h0);
    chk(req, "reset wb_en", {31'h0, wb_en_o}, 32'h0);
    chk(req, "reset st_en", {31'h0, st_en_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // one lockstep cycle: compare, advance model, wait for the executing edge
  task automatic step(input string req);
    logic [31:0] ins, a, b, imm, val, npc, saddr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, dst;
    logic        en, st;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    imm = {{16{ins[15]}}, ins[15:0]};
    a = m_reg[rs]; b = m_reg[rt];
    npc = m_pc + 32'd4; en = 1'b0; st = 1'b0; dst = rt; val = 32'h0; saddr = 32'h0;
    if (op == 6'h00) begin
      dst = rd;
      en  = 1'b1;
      if (fn == 6'h20)      val = a + b;
      else if (fn == 6'h22) val = a - b;
      else if (fn == 6'h24) val = a & b;
      else if (fn == 6'h25) val = a | b;
      else if (fn == 6'h2A) val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      else en = 1'b0;
    end else if (op == 6'h08) begin
      en = 1'b1; val = a + imm;
    end else if (op == 6'h23) begin
      en = 1'b1; saddr = a + imm; val = m_mem[saddr[7:2]];
    end else if (op == 6'h2B) begin
      st = 1'b1; saddr = a + imm;
    end else if (op == 6'h04) begin
      if (a == b) npc = m_pc + 32'd4 + (imm << 2);
    end else if (op == 6'h02) begin
      npc = {m_pc[31:28], ins[25:0], 2'b00};
    end
    en = en && (dst != 5'd0);

    chk(req, "pc", pc_o, m_pc);
    chk(req, "wb_en", {31'h0, wb_en_o}, {31'h0, en});
    if (en) begin
      chk(req, "wb_reg", {27'h0, wb_reg_o}, {27'h0, dst});
      chk(req, "wb_data", wb_data_o, val);
    end
    chk(req, "st_en", {31'h0, st_en_o}, {31'h0, st});
    if (st) begin
      chk(req, "st_addr", st_addr_o, saddr);
      chk(req, "st_data", st_data_o, b);
    end

    if (en) m_reg[dst] = val;
    if (st) m_mem[saddr[7:2]] = b;
    m_pc = npc;
    @(negedge clk);
    #1;
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < 64; i++) begin
      peek_addr = 6'(i);
      #0.2;
      chk(req, "dmem word", peek_data, m_mem[i]);
    end
  endtask

  // R1: reset state, and reset asserted mid-run
  task automatic t_reset();
    clear_prog();
    prog[0] = i_i(6'h08, 5'd1, 5'd0, 16'd5);
    prog[1] = i_i(6'h08, 5'd2, 5'd1, 16'd1);
    prog[2] = halt_i();
    start("R1");
    run("R1", 2);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc after mid-run reset", pc_o, 32'h0);
    chk("R1", "wb_en in reset", {31'h0, wb_en_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    run("R1", 4);
  endtask

  // R3 R4 R11: arithmetic, logic, signed compare, back-to-back use
  task automatic t_alu();
    clear_prog();
    prog[0] = i_i(6'h08, 5'd1, 5'd0, 16'd7);
    prog[1] = i_i(6'h08, 5'd2, 5'd0, 16'hFFFD);
    prog[2] = r_i(6'h20, 5'd3, 5'd1, 5'd2);
    prog[3] = r_i(6'h22, 5'd4, 5'd2, 5'd1);
    prog[4] = r_i(6'h24, 5'd5, 5'd1, 5'd2);
    prog[5] = r_i(6'h25, 5'd6, 5'd1, 5'd2);
    prog[6] = r_i(6'h2A, 5'd7, 5'd2, 5'd1);
    prog[7] = r_i(6'h2A, 5'd8, 5'd1, 5'd2);
    prog[8] = r_i(6'h20, 5'd9, 5'd3, 5'd3);
    prog[9] = halt_i();
    start("R3/R4/R11");
    run("R3/R4/R11", 13);
  endtask

  // R5 R6: loads, stores, negative offsets
  task automatic t_mem();
    clear_prog();
    prog[0] = i_i(6'h08, 5'd3, 5'd0, 16'd16);
    prog[1] = i_i(6'h23, 5'd1, 5'd0, 16'd8);
    prog[2] = i_i(6'h23, 5'd2, 5'd3, 16'hFFFC);
    prog[3] = i_i(6'h2B, 5'd1, 5'd0, 16'd32);
    prog[4] = i_i(6'h2B, 5'd2, 5'd3, 16'd4);
    prog[5] = i_i(6'h23, 5'd4, 5'd0, 16'd32);
    prog[6] = r_i(6'h20, 5'd5, 5'd4, 5'd2);
    prog[7] = i_i(6'h2B, 5'd5, 5'd3, 16'hFFF0);
    prog[8] = halt_i();
    start("R5/R6");
    run("R5/R6", 12);
    check_mem("R5/R6");
  endtask

  // R2 R7: forward taken, not taken, backward loop
  task automatic t_branch();
    clear_prog();
    prog[0]  = i_i(6'h08, 5'd1, 5'd0, 16'd1);
    prog[1]  = i_i(6'h08, 5'd2, 5'd0, 16'd1);
    prog[2]  = i_i(6'h04, 5'd2, 5'd1, 16'd2);
    prog[3]  = i_i(6'h08, 5'd3, 5'd0, 16'd99);
    prog[4]  = i_i(6'h08, 5'd4, 5'd0, 16'd99);
    prog[5]  = i_i(6'h08, 5'd5, 5'd0, 16'd2);
    prog[6]  = i_i(6'h04, 5'd5, 5'd1, 16'd5);
    prog[7]  = i_i(6'h08, 5'd6, 5'd0, 16'd3);
    prog[8]  = i_i(6'h08, 5'd6, 5'd6, 16'hFFFF);
    prog[9]  = i_i(6'h04, 5'd0, 5'd6, 16'd1);
    prog[10] = i_i(6'h04, 5'd0, 5'd0, 16'hFFFD);
    prog[11] = i_i(6'h2B, 5'd6, 5'd0, 16'd0);
    prog[12] = halt_i();
    start("R2/R7");
    run("R2/R7", 24);
    check_mem("R2/R7");
  endtask

  // R8: forward and backward jumps
  task automatic t_jump();
    clear_prog();
    prog[0] = j_i(26'd5);
    prog[1] = i_i(6'h08, 5'd1, 5'd0, 16'd11);
    prog[2] = i_i(6'h08, 5'd3, 5'd0, 16'd33);
    prog[3] = j_i(26'd8);
    prog[5] = i_i(6'h08, 5'd2, 5'd0, 16'd22);
    prog[6] = j_i(26'd2);
    prog[8] = halt_i();
    start("R8");
    run("R8", 10);
  endtask

  // R9 R10: register 0, unknown opcode and function code
  task automatic t_zero_illegal();
    clear_prog();
    prog[0] = i_i(6'h08, 5'd1, 5'd0, 16'd9);
    prog[1] = i_i(6'h08, 5'd0, 5'd0, 16'd5);
    prog[2] = r_i(6'h20, 5'd2, 5'd0, 5'd1);
    prog[3] = 32'hFC221234;
    prog[4] = r_i(6'h27, 5'd3, 5'd1, 5'd1);
    prog[5] = r_i(6'h20, 5'd0, 5'd1, 5'd1);
    prog[6] = i_i(6'h2B, 5'd0, 5'd0, 16'd4);
    prog[7] = i_i(6'h2B, 5'd3, 5'd0, 16'd8);
    prog[8] = halt_i();
    start("R9/R10");
    run("R9/R10", 11);
    check_mem("R9/R10");
  endtask

  initial begin
    rst_n = 1'b1; load_en = 1'b0; load_imem = 1'b0;
    load_addr = '0; load_data = '0; peek_addr = '0;
    #1 rst_n = 1'b0;
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule